// File: doc/BRIEF.md
# Opcode-Fetch Character Row Generator

This block rides on an 8-bit CPU's instruction-fetch machine cycles to turn the display list into character pixel rows. When the CPU fetches an opcode from display memory, the block watches the byte that the memory puts on the bus and keeps it as a character code. It then makes the CPU see a zero byte, a no-operation, so the display list is never actually executed. The block also drives the CPU side of the data bus with zero in the second clock state.

In the refresh half of the same machine cycle the CPU's own address is cut off from the character ROM. The block puts a glyph address on the ROM instead, built from the kept code and the current row within the character cell. The ROM stays selected the whole time; only its address moves. The byte the ROM returns is sampled at the end of the fourth clock state. It is inverted when the character code's top bit is set, and it is presented as one pixel row with a single-cycle valid strobe.

The clock runs one cycle per CPU clock state. The `tstate` input names the current state in the encoding 0=T1, 1=T2, 2=T3, 3=T4. A separate pulse input steps the cell-row counter once per scanline.

Top module: `vidfetch_ctrl`

## Requirements
- R1: After reset, `pixel_valid`, `bus_drive_en` and `rom_ovr_en` are low, and the row counter is 0. The first display fetch therefore addresses row 0.
- R2: A cycle is a display fetch when, with `tstate`=0 (T1), `m1_n` is low, `cpu_addr[15]` is 1 and `mem_data[6]` is 0. In any other case `cpu_rd_data` equals `mem_data`, and `bus_drive_en`, `rom_ovr_en` and `pixel_valid` stay low for that machine cycle.
- R3: During T1 and T2 of a display fetch, `cpu_rd_data` is 0x00 whatever `mem_data` carries. During T3 and T4 it equals `mem_data`.
- R4: `bus_drive_en` is high during T2 (`tstate`=1) of a display fetch and low in every other cycle.
- R5: During T3 and T4 (`tstate`=2,3) of a display fetch, `rom_ovr_en` is high and `rom_addr` = 0x1E00 | (code[5:0] << 3) | row. Here code is the `mem_data` byte kept at T1. Outside those cycles `rom_ovr_en` is low and `rom_addr` is 0.
- R6: In the cycle after T4 of a display fetch, `pixel_valid` is high for exactly one cycle. `pixel_out` holds the `mem_data` byte sampled in T4. Without a display fetch `pixel_valid` stays low.
- R7: When bit 7 of the kept code is 1, `pixel_out` is the bitwise complement of the sampled ROM byte.
- R8: Each cycle with `line_step` high advances the row by one, and the row wraps from 7 to 0.
- R9: The row used by a glyph fetch is the value held at the end of that fetch's T1. A `line_step` pulse in that T1 or later in the same machine cycle changes only the following fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per CPU clock state |
| rst_n | input | 1 | Asynchronous active-low reset |
| tstate | input | 2 | Current clock state: 0=T1, 1=T2, 2=T3, 3=T4 |
| m1_n | input | 1 | Active-low opcode-fetch strobe |
| rfsh_n | input | 1 | Active-low memory-refresh strobe |
| cpu_addr | input | 16 | CPU address bus |
| mem_data | input | 8 | Data bus as driven by memory and ROM |
| line_step | input | 1 | One pulse per scanline, advances the cell row |
| cpu_rd_data | output | 8 | Byte presented to the CPU's data inputs |
| bus_drive_en | output | 1 | Block drives the CPU data bus (with zero) |
| rom_ovr_en | output | 1 | Glyph address replaces the CPU address at the ROM |
| rom_addr | output | 13 | Glyph address for the character ROM |
| pixel_out | output | 8 | Pixel row, inverted for top-bit characters |
| pixel_valid | output | 1 | One-cycle strobe qualifying `pixel_out` |

## Verification
The row counter can step in the same cycle that a glyph fetch is using a row. A `line_step` pulse that lands in T1, T2, T3 or T4 of a display fetch must leave that fetch's ROM address on the old row and move only later fetches. The bench provokes this with directed fetches that pulse the step in each of the four states, and with random step pulses scattered over random fetch streams. A reference row count, sampled at the end of T1 as the requirements define, judges every `rom_addr` seen in T3 and T4. A second overlap, where the pixel strobe of one fetch falls in T1 of the next fetch, is judged in that same T1 cycle.

// File: rtl/vf_pkg.sv
package vf_pkg;

  typedef enum logic [1:0] {
    TS_T1 = 2'd0,
    TS_T2 = 2'd1,
    TS_T3 = 2'd2,
    TS_T4 = 2'd3
  } tstate_e;

endpackage

// File: rtl/vf_line_ctr.sv
module vf_line_ctr #(
  parameter int LINE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  output logic [LINE_BITS-1:0] line_q
);

  logic [LINE_BITS-1:0] line_nxt;
  logic                 line_en;

  // natural binary wrap gives the modulo-2^LINE_BITS row count
  always_comb begin
    line_en  = step;
    line_nxt = line_q + LINE_BITS'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (line_en) begin
      line_q <= line_nxt;
    end
  end

endmodule

// File: rtl/vf_fetch_seq.sv
module vf_fetch_seq
  import vf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_BITS = 3,
  parameter int SKIP_BIT  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tstate_e              ts,
  input  logic                 m1_n,
  input  logic                 addr_hi,
  input  logic [DATA_W-1:0]    mem_data,
  input  logic [LINE_BITS-1:0] line_q,
  output logic                 qual_now,
  output logic                 disp_q,
  output logic [DATA_W-1:0]    code_q,
  output logic [LINE_BITS-1:0] line_cap_q
);

  logic                 disp_nxt;
  logic                 cap_en;
  logic                 disp_en;

  // live qualification of a display fetch in T1
  always_comb begin
    qual_now = (ts == TS_T1) && !m1_n && addr_hi && !mem_data[SKIP_BIT];
  end

  // display flag: decided at end of T1, cleared at end of T4
  always_comb begin
    disp_en  = 1'b0;
    disp_nxt = disp_q;
    if (ts == TS_T1) begin
      disp_en  = 1'b1;
      disp_nxt = qual_now;
    end else if (ts == TS_T4) begin
      disp_en  = 1'b1;
      disp_nxt = 1'b0;
    end
    cap_en = qual_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= 1'b0;
    end else if (disp_en) begin
      disp_q <= disp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q     <= '0;
      line_cap_q <= '0;
    end else if (cap_en) begin
      code_q     <= mem_data;
      line_cap_q <= line_q;
    end
  end

endmodule

// File: rtl/vf_glyph_path.sv
module vf_glyph_path
  import vf_pkg::*;
#(
  parameter int                 DATA_W    = 8,
  parameter int                 CODE_BITS = 6,
  parameter int                 LINE_BITS = 3,
  parameter int                 ROM_AW    = 13,
  parameter logic [ROM_AW-1:0]  ROM_BASE  = 13'h1E00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tstate_e              ts,
  input  logic                 disp_q,
  input  logic [DATA_W-1:0]    code_q,
  input  logic [LINE_BITS-1:0] line_cap_q,
  input  logic [DATA_W-1:0]    mem_data,
  output logic                 rom_ovr_en,
  output logic [ROM_AW-1:0]    rom_addr,
  output logic [DATA_W-1:0]    pixel_q,
  output logic                 pixel_valid_q
);

  localparam int OFF_W = CODE_BITS + LINE_BITS;

  logic [OFF_W-1:0]  glyph_off;
  logic              in_rfsh;
  logic              inv;
  logic [DATA_W-1:0] pixel_nxt;
  logic              pv_nxt;
  logic              pix_en;

  always_comb begin
    in_rfsh    = (ts == TS_T3) || (ts == TS_T4);
    rom_ovr_en = disp_q && in_rfsh;
    glyph_off  = {code_q[CODE_BITS-1:0], line_cap_q};
    rom_addr   = rom_ovr_en ? (ROM_BASE | ROM_AW'(glyph_off)) : '0;
  end

  always_comb begin
    inv       = code_q[DATA_W-1];
    pixel_nxt = mem_data ^ {DATA_W{inv}};
    pix_en    = disp_q && (ts == TS_T4);
    pv_nxt    = pix_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixel_valid_q <= 1'b0;
    end else begin
      pixel_valid_q <= pv_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixel_q <= '0;
    end else if (pix_en) begin
      pixel_q <= pixel_nxt;
    end
  end

endmodule

// File: rtl/vidfetch_ctrl.sv
module vidfetch_ctrl
  import vf_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                CODE_BITS = 6,
  parameter int                LINE_BITS = 3,
  parameter int                ROM_AW    = 13,
  parameter logic [ROM_AW-1:0] ROM_BASE  = 13'h1E00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tstate,
  input  logic              m1_n,
  input  logic              rfsh_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              line_step,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              bus_drive_en,
  output logic              rom_ovr_en,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [DATA_W-1:0] pixel_out,
  output logic              pixel_valid
);

  localparam int SKIP_BIT = DATA_W - 2;

  tstate_e              ts;
  logic [LINE_BITS-1:0] line_q;
  logic [LINE_BITS-1:0] line_cap_q;
  logic                 qual_now;
  logic                 disp_q;
  logic [DATA_W-1:0]    code_q;
  logic                 force_zero;
  logic                 rfsh_unused;

  always_comb begin
    ts          = tstate_e'(tstate);
    rfsh_unused = rfsh_n;
  end

  vf_line_ctr #(
    .LINE_BITS (LINE_BITS)
  ) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (line_step),
    .line_q (line_q)
  );

  vf_fetch_seq #(
    .DATA_W    (DATA_W),
    .LINE_BITS (LINE_BITS),
    .SKIP_BIT  (SKIP_BIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts         (ts),
    .m1_n       (m1_n),
    .addr_hi    (cpu_addr[ADDR_W-1]),
    .mem_data   (mem_data),
    .line_q     (line_q),
    .qual_now   (qual_now),
    .disp_q     (disp_q),
    .code_q     (code_q),
    .line_cap_q (line_cap_q)
  );

  vf_glyph_path #(
    .DATA_W    (DATA_W),
    .CODE_BITS (CODE_BITS),
    .LINE_BITS (LINE_BITS),
    .ROM_AW    (ROM_AW),
    .ROM_BASE  (ROM_BASE)
  ) u_glyph (
    .clk           (clk),
    .rst_n         (rst_n),
    .ts            (ts),
    .disp_q        (disp_q),
    .code_q        (code_q),
    .line_cap_q    (line_cap_q),
    .mem_data      (mem_data),
    .rom_ovr_en    (rom_ovr_en),
    .rom_addr      (rom_addr),
    .pixel_q       (pixel_out),
    .pixel_valid_q (pixel_valid)
  );

  // NOP substitution: live in T1, from the registered flag in T2
  always_comb begin
    bus_drive_en = disp_q && (ts == TS_T2);
    force_zero   = qual_now || bus_drive_en;
    cpu_rd_data  = force_zero ? '0 : mem_data;
  end

endmodule

// File: rtl/vidfetch_ctrl_chk.sv
module vidfetch_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_AW = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        tstate,
  input logic              m1_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [DATA_W-1:0] cpu_rd_data,
  input logic              bus_drive_en,
  input logic              rom_ovr_en,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              pixel_valid
);

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == 2'd0 && (m1_n || !cpu_addr[ADDR_W-1] || mem_data[DATA_W-2]))
      |-> (cpu_rd_data == mem_data && !bus_drive_en && !rom_ovr_en));

  assert_drive_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> (cpu_rd_data == '0));

  assert_drive_t2_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> (tstate == 2'd1));

  assert_ovr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ovr_en |-> (tstate == 2'd2 || tstate == 2'd3));

  assert_addr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ovr_en |-> (rom_addr == '0));

  assert_ovr_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_ovr_en && tstate == 2'd2) |=> (rom_ovr_en || tstate != 2'd3));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid |=> !pixel_valid);

  assert_strobe_after_t4_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pixel_valid) |-> ($past(tstate) == 2'd3 && $past(rom_ovr_en)));

endmodule

bind vidfetch_ctrl vidfetch_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ROM_AW (ROM_AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tstate       (tstate),
  .m1_n         (m1_n),
  .cpu_addr     (cpu_addr),
  .mem_data     (mem_data),
  .cpu_rd_data  (cpu_rd_data),
  .bus_drive_en (bus_drive_en),
  .rom_ovr_en   (rom_ovr_en),
  .rom_addr     (rom_addr),
  .pixel_valid  (pixel_valid)
);

// File: tb/vidfetch_ctrl_tb.sv
`timescale 1ns/1ps
module vidfetch_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  tstate;
  logic        m1_n;
  logic        rfsh_n;
  logic [15:0] cpu_addr;
  logic [7:0]  mem_data;
  logic        line_step;
  logic [7:0]  cpu_rd_data;
  logic        bus_drive_en;
  logic        rom_ovr_en;
  logic [12:0] rom_addr;
  logic [7:0]  pixel_out;
  logic        pixel_valid;

  int n_chk;
  int n_bad;
  int cyc;

  // reference state
  logic [2:0] row_m;
  logic       pend_pv;
  logic [7:0] pend_pix;

  vidfetch_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tstate       (tstate),
    .m1_n         (m1_n),
    .rfsh_n       (rfsh_n),
    .cpu_addr     (cpu_addr),
    .mem_data     (mem_data),
    .line_step    (line_step),
    .cpu_rd_data  (cpu_rd_data),
    .bus_drive_en (bus_drive_en),
    .rom_ovr_en   (rom_ovr_en),
    .rom_addr     (rom_addr),
    .pixel_out    (pixel_out),
    .pixel_valid  (pixel_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic is_disp(logic [15:0] a, logic [7:0] d, logic m1n);
    return !m1n && a[15] && !d[6];
  endfunction

  function automatic logic [12:0] glyph_addr(logic [7:0] code, logic [2:0] row);
    return 13'h1E00 | {4'd0, code[5:0], row};
  endfunction

  function automatic logic [7:0] pix_of(logic [7:0] code, logic [7:0] rom);
    return code[7] ? ~rom : rom;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive inputs on negedge, check combinational outputs shortly after;
  // the step is applied by the counter at the next posedge
  task automatic drive(logic [1:0] ts, logic m1n, logic rfn, logic [15:0] a,
                       logic [7:0] d, logic st);
    @(negedge clk);
    tstate    = ts;
    m1_n      = m1n;
    rfsh_n    = rfn;
    cpu_addr  = a;
    mem_data  = d;
    line_step = st;
    #1;
  endtask

  task automatic check_pending(string req);
    chk({req, " pixel_valid"}, {31'd0, pixel_valid}, {31'd0, pend_pv});
    if (pend_pv) chk({req, " pixel_out"}, {24'd0, pixel_out}, {24'd0, pend_pix});
  endtask

  // one opcode-fetch machine cycle; steps[k] pulses line_step in state k
  task automatic fetch(logic m1n, logic [15:0] a, logic [7:0] code,
                       logic [7:0] junk, logic [7:0] rom3, logic [7:0] rom4,
                       logic [3:0] steps);
    logic       d;
    logic [2:0] row_cap;
    d = is_disp(a, code, m1n);
    // T1
    drive(2'd0, m1n, 1'b1, a, code, steps[0]);
    check_pending("R6");
    chk("R2/R3 T1 rd_data", {24'd0, cpu_rd_data}, {24'd0, d ? 8'h00 : code});
    chk("R4 T1 drive", {31'd0, bus_drive_en}, 32'd0);
    chk("R5 T1 ovr", {31'd0, rom_ovr_en}, 32'd0);
    row_cap = row_m;
    if (steps[0]) row_m = row_m + 3'd1;
    // T2
    drive(2'd1, m1n, 1'b1, a, junk, steps[1]);
    chk("R2/R3 T2 rd_data", {24'd0, cpu_rd_data}, {24'd0, d ? 8'h00 : junk});
    chk("R4 T2 drive", {31'd0, bus_drive_en}, {31'd0, d});
    chk("R2 pv T2", {31'd0, pixel_valid}, 32'd0);
    if (steps[1]) row_m = row_m + 3'd1;
    // T3
    drive(2'd2, 1'b1, 1'b0, {$urandom} % 65536, rom3, steps[2]);
    chk("R3 T3 rd_data", {24'd0, cpu_rd_data}, {24'd0, rom3});
    chk("R4 T3 drive", {31'd0, bus_drive_en}, 32'd0);
    chk("R5 T3 ovr", {31'd0, rom_ovr_en}, {31'd0, d});
    chk("R5/R9 T3 rom_addr", {19'd0, rom_addr}, {19'd0, d ? glyph_addr(code, row_cap) : 13'd0});
    if (steps[2]) row_m = row_m + 3'd1;
    // T4
    drive(2'd3, 1'b1, 1'b0, {$urandom} % 65536, rom4, steps[3]);
    chk("R5 T4 ovr", {31'd0, rom_ovr_en}, {31'd0, d});
    chk("R5/R9 T4 rom_addr", {19'd0, rom_addr}, {19'd0, d ? glyph_addr(code, row_cap) : 13'd0});
    if (steps[3]) row_m = row_m + 3'd1;
    pend_pv  = d;
    pend_pix = pix_of(code, rom4);
  endtask

  task automatic idle_cycle(logic st);
    drive(2'd1, 1'b1, 1'b1, 16'hFFFF, 8'h00, st);
    check_pending("R6 idle");
    chk("R2 idle rd_data", {24'd0, cpu_rd_data}, 32'd0);
    chk("R4 idle drive", {31'd0, bus_drive_en}, 32'd0);
    pend_pv = 1'b0;
    if (st) row_m = row_m + 3'd1;
  endtask

  // watchdog
  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    n_chk = 0; n_bad = 0; cyc = 0;
    row_m = 3'd0; pend_pv = 1'b0; pend_pix = 8'h00;
    rst_n = 1'b0; tstate = 2'd0; m1_n = 1'b1; rfsh_n = 1'b1;
    cpu_addr = 16'h0000; mem_data = 8'h00; line_step = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pixel_valid", {31'd0, pixel_valid}, 32'd0);
    chk("R1 reset drive", {31'd0, bus_drive_en}, 32'd0);
    chk("R1 reset ovr", {31'd0, rom_ovr_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: first display fetch uses row 0
    fetch(1'b0, 16'hC000, 8'h15, 8'hAA, 8'h11, 8'h3C, 4'b0000);
    // R7: inverted character, R2: non-display fetches
    fetch(1'b0, 16'h8123, 8'h9F, 8'h77, 8'h22, 8'h0F, 4'b0000);
    fetch(1'b0, 16'h8123, 8'h40, 8'h55, 8'h22, 8'h0F, 4'b0000); // bit 6 set
    fetch(1'b0, 16'h7FFF, 8'h05, 8'h55, 8'h22, 8'h0F, 4'b0000); // low half
    fetch(1'b1, 16'hC000, 8'h05, 8'h55, 8'h22, 8'h0F, 4'b0000); // no M1
    // R8: wrap after eight steps
    for (int k = 0; k < 7; k++) idle_cycle(1'b1);
    fetch(1'b0, 16'hC001, 8'h3F, 8'h01, 8'h02, 8'h80, 4'b0000);
    idle_cycle(1'b1);
    chk("R8 wrap model row", {29'd0, row_m}, 32'd0);
    fetch(1'b0, 16'hC002, 8'h01, 8'h01, 8'h02, 8'hFF, 4'b0000);
    // R9: step in each state of a display fetch
    for (int k = 0; k < 4; k++)
      fetch(1'b0, 16'hE000 + 16'(k), 8'h0A + 8'(k), 8'h99, 8'h66, 8'h5A, 4'(1 << k));
    // back-to-back display fetches, then random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  c;
      a = 16'($urandom);
      c = 8'($urandom);
      if (($urandom % 4) != 0) begin
        a[15] = 1'b1;
        c[6]  = 1'b0;
      end
      fetch(($urandom % 8) == 0, a, c, 8'($urandom), 8'($urandom), 8'($urandom),
            4'($urandom) & 4'($urandom));
      if (($urandom % 5) == 0) idle_cycle(($urandom % 2) == 1);
    end
    idle_cycle(1'b0);
    idle_cycle(1'b0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule